// File: doc/BRIEF.md
# Branch Misprediction Flush Controller

This block watches the instruction at the branch-resolving stage of a five-stage in-order pipeline. The front end carries a predicted next PC with every instruction. The block computes the real successor of that instruction and compares it with the prediction. On a mismatch it kills the younger front-end stages and steers fetch to the corrected address, all in the same cycle. When the prediction holds, it does nothing to the pipeline.

A parameter picks where resolution happens. Resolving in execute leaves two wrong-path instructions, in fetch and decode, to discard. Resolving in decode leaves one, in fetch. The comparison is made for every valid instruction, not only branches. An instruction that is not a branch but was given a non-sequential prediction, for example by a stale target-cache hit, is therefore also recovered.

Every valid branch that resolves produces a single-cycle training record one cycle later. The record carries the branch PC, its direction, its target and whether it was mispredicted, for the predictor tables to consume.

Top module: `branch_flush_ctrl`

## Requirements
- R1: The true successor of the resolving instruction is its target when it is a branch that is taken, otherwise its PC plus INSN_BYTES (4), wrapping modulo 2^32.
- R2: When the resolving stage is valid and the true successor differs from the carried prediction, `redir_vld` is high in that same cycle and `redir_pc` equals the true successor. This also applies to non-branch instructions.
- R3: When the carried prediction equals the true successor, `redir_vld` stays low and `stg_kill` is zero.
- R4: `stg_kill` bit 0 is fetch, bit 1 is decode and bit 2 is execute. On a misprediction, every bit below RES_STAGE is set and no other bit is set. With RES_STAGE=2 (execute) the value is 3'b011. With RES_STAGE=1 (decode) it is 3'b001.
- R5: When the valid bit of the resolving stage is low, no redirect, no kill and no training record result, whatever the other resolve inputs are.
- R6: `fe_next_pc` equals `redir_pc` whenever `redir_vld` is high, and equals `fe_pred_npc` otherwise.
- R7: One cycle after a valid branch resolves, `upd_vld` is high for that cycle with the branch's PC, direction, target and misprediction flag. A valid non-branch produces no record.
- R8: Reset is synchronous and active high. While `rst` is high there is no redirect and no kill, and `upd_vld` is low in the cycle after a reset edge.
- R9: `stg_live` equals `stg_vld` with every killed stage cleared, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stg_vld | input | 3 | Valid bits of fetch (0), decode (1), execute (2) |
| rs_pc | input | 32 | PC of the instruction at the resolving stage |
| rs_pred_npc | input | 32 | Next PC predicted for that instruction at fetch |
| rs_is_br | input | 1 | Resolving instruction is a control-flow instruction |
| rs_taken | input | 1 | Resolved direction |
| rs_target | input | 32 | Resolved target |
| fe_pred_npc | input | 32 | Next PC proposed by the fetch predictor this cycle |
| stg_kill | output | 3 | Per-stage kill, same bit order as `stg_vld` |
| stg_live | output | 3 | Valid bits after kills are applied |
| redir_vld | output | 1 | Fetch redirect request |
| redir_pc | output | 32 | Corrected fetch address |
| fe_next_pc | output | 32 | Selected next fetch PC |
| upd_vld | output | 1 | Training record valid (one cycle) |
| upd_pc | output | 32 | PC of the resolved branch |
| upd_taken | output | 1 | Direction of the resolved branch |
| upd_target | output | 32 | Target of the resolved branch |
| upd_mispred | output | 1 | The branch was mispredicted |

## Verification
The bench builds two copies side by side. One uses RES_STAGE=2 and the other RES_STAGE=1, and both receive the same stimulus. This shows two kills in one copy and one kill in the other for the same event. Some valid patterns leave execute empty while decode holds an instruction, so only the decode-resolving copy reacts, and the difference is visible at the ports. Address wrap, false predictions on non-branches, and back-to-back training records are each driven through both copies.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

    localparam int unsigned PC_W    = 32;
    localparam int unsigned N_FE    = 3;
    localparam int unsigned IDX_IF  = 0;
    localparam int unsigned IDX_ID  = 1;
    localparam int unsigned IDX_EX  = 2;

    typedef logic [PC_W-1:0] pc_t;

    typedef struct packed {
        logic vld;
        pc_t  pc;
        pc_t  pred_npc;
        logic is_br;
        logic taken;
        pc_t  target;
    } resolve_t;

    typedef struct packed {
        logic vld;
        pc_t  pc;
        logic taken;
        pc_t  target;
        logic mispred;
    } train_t;

    function automatic pc_t true_successor(resolve_t r, pc_t step);
        if (r.is_br && r.taken)
            return r.target;
        return r.pc + step;
    endfunction

endpackage

// File: rtl/bfc_outcome.sv
module bfc_outcome
    import bfc_pkg::*;
#(
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic     rst,
    input  resolve_t rs,
    output logic     mispred,
    output pc_t      fix_pc
);
    localparam pc_t STEP = pc_t'(INSN_BYTES);

    pc_t succ;

    always_comb begin
        succ    = true_successor(rs, STEP);
        fix_pc  = succ;
        mispred = !rst && rs.vld && (succ != rs.pred_npc);
    end
endmodule

// File: rtl/bfc_kill_gen.sv
module bfc_kill_gen
    import bfc_pkg::*;
#(
    parameter int unsigned RES_STAGE = IDX_EX
) (
    input  logic            mispred,
    input  logic [N_FE-1:0] vld_in,
    output logic [N_FE-1:0] kill,
    output logic [N_FE-1:0] live
);
    for (genvar g = 0; g < N_FE; g++) begin : g_stage
        if (g < RES_STAGE) begin : g_young
            assign kill[g] = mispred;
        end else begin : g_old
            assign kill[g] = 1'b0;
        end
        assign live[g] = vld_in[g] & ~kill[g];
    end
endmodule

// File: rtl/bfc_train_reg.sv
module bfc_train_reg
    import bfc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  resolve_t rs,
    input  logic     mispred,
    output train_t   rec
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rec <= '0;
        end else begin
            rec.vld     <= rs.vld && rs.is_br;
            rec.pc      <= rs.pc;
            rec.taken   <= rs.taken;
            rec.target  <= rs.target;
            rec.mispred <= mispred;
        end
    end
endmodule

// File: rtl/branch_flush_ctrl.sv
module branch_flush_ctrl
    import bfc_pkg::*;
#(
    parameter int unsigned RES_STAGE  = 2,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2:0]      stg_vld,
    input  logic [31:0]     rs_pc,
    input  logic [31:0]     rs_pred_npc,
    input  logic            rs_is_br,
    input  logic            rs_taken,
    input  logic [31:0]     rs_target,
    input  logic [31:0]     fe_pred_npc,
    output logic [2:0]      stg_kill,
    output logic [2:0]      stg_live,
    output logic            redir_vld,
    output logic [31:0]     redir_pc,
    output logic [31:0]     fe_next_pc,
    output logic            upd_vld,
    output logic [31:0]     upd_pc,
    output logic            upd_taken,
    output logic [31:0]     upd_target,
    output logic            upd_mispred
);
    resolve_t rs;
    train_t   rec;
    logic     mispred;
    pc_t      fix_pc;

    always_comb begin
        rs.vld      = stg_vld[RES_STAGE];
        rs.pc       = rs_pc;
        rs.pred_npc = rs_pred_npc;
        rs.is_br    = rs_is_br;
        rs.taken    = rs_taken;
        rs.target   = rs_target;
    end

    bfc_outcome #(.INSN_BYTES(INSN_BYTES)) u_outcome (
        .rst     (rst),
        .rs      (rs),
        .mispred (mispred),
        .fix_pc  (fix_pc)
    );

    bfc_kill_gen #(.RES_STAGE(RES_STAGE)) u_kill (
        .mispred (mispred),
        .vld_in  (stg_vld),
        .kill    (stg_kill),
        .live    (stg_live)
    );

    bfc_train_reg u_train (
        .clk     (clk),
        .rst     (rst),
        .rs      (rs),
        .mispred (mispred),
        .rec     (rec)
    );

    assign redir_vld   = mispred;
    assign redir_pc    = fix_pc;
    assign fe_next_pc  = mispred ? fix_pc : fe_pred_npc;

    assign upd_vld     = rec.vld;
    assign upd_pc      = rec.pc;
    assign upd_taken   = rec.taken;
    assign upd_target  = rec.target;
    assign upd_mispred = rec.mispred;
endmodule

// File: rtl/bfc_checker.sv
module bfc_checker #(
    parameter int unsigned RES_STAGE = 2
) (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  stg_vld,
    input logic        rs_is_br,
    input logic [31:0] rs_pred_npc,
    input logic [2:0]  stg_kill,
    input logic        redir_vld,
    input logic [31:0] redir_pc,
    input logic [31:0] fe_next_pc,
    input logic        upd_vld
);
    AST_REDIR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        redir_vld |-> stg_vld[RES_STAGE]); // R5
    AST_REDIR_DIFFERS: assert property (@(posedge clk) disable iff (rst)
        redir_vld |-> (redir_pc != rs_pred_npc)); // R2
    AST_FETCH_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        redir_vld |-> (fe_next_pc == redir_pc)); // R6
    AST_KILL_COUNT: assert property (@(posedge clk) disable iff (rst)
        redir_vld |-> ($countones(stg_kill) == RES_STAGE)); // R4
    AST_KILL_ONLY_ON_REDIR: assert property (@(posedge clk) disable iff (rst)
        !redir_vld |-> (stg_kill == 3'b000)); // R3
    AST_UPD_FOLLOWS_BRANCH: assert property (@(posedge clk) disable iff (rst)
        upd_vld |-> $past(stg_vld[RES_STAGE] && rs_is_br)); // R7
    AST_QUIET_IN_RESET: assert property (@(posedge clk)
        rst |-> (!redir_vld && stg_kill == 3'b000)); // R8
endmodule

bind branch_flush_ctrl bfc_checker #(.RES_STAGE(RES_STAGE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .stg_vld     (stg_vld),
    .rs_is_br    (rs_is_br),
    .rs_pred_npc (rs_pred_npc),
    .stg_kill    (stg_kill),
    .redir_vld   (redir_vld),
    .redir_pc    (redir_pc),
    .fe_next_pc  (fe_next_pc),
    .upd_vld     (upd_vld)
);

// File: tb/branch_flush_ctrl_tb.sv
module branch_flush_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  stg_vld = '0;
    logic [31:0] rs_pc = '0, rs_pred_npc = '0, rs_target = '0, fe_pred_npc = '0;
    logic        rs_is_br = 1'b0, rs_taken = 1'b0;

    logic [2:0]  kill_e, live_e, kill_i, live_i;
    logic        rv_e, rv_i, uv_e, uv_i, ut_e, ut_i, um_e, um_i;
    logic [31:0] rp_e, rp_i, fn_e, fn_i, up_e, up_i, utg_e, utg_i;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic        ve, vi, me, mi, tk;
        logic [31:0] pc, tgt;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    branch_flush_ctrl #(.RES_STAGE(2)) u_dut (
        .clk(clk), .rst(rst), .stg_vld(stg_vld), .rs_pc(rs_pc), .rs_pred_npc(rs_pred_npc),
        .rs_is_br(rs_is_br), .rs_taken(rs_taken), .rs_target(rs_target), .fe_pred_npc(fe_pred_npc),
        .stg_kill(kill_e), .stg_live(live_e), .redir_vld(rv_e), .redir_pc(rp_e), .fe_next_pc(fn_e),
        .upd_vld(uv_e), .upd_pc(up_e), .upd_taken(ut_e), .upd_target(utg_e), .upd_mispred(um_e));

    branch_flush_ctrl #(.RES_STAGE(1)) u_dut_id (
        .clk(clk), .rst(rst), .stg_vld(stg_vld), .rs_pc(rs_pc), .rs_pred_npc(rs_pred_npc),
        .rs_is_br(rs_is_br), .rs_taken(rs_taken), .rs_target(rs_target), .fe_pred_npc(fe_pred_npc),
        .stg_kill(kill_i), .stg_live(live_i), .redir_vld(rv_i), .redir_pc(rp_i), .fe_next_pc(fn_i),
        .upd_vld(uv_i), .upd_pc(up_i), .upd_taken(ut_i), .upd_target(utg_i), .upd_mispred(um_i));

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus, checks same-cycle outputs, queues the training record.
    task automatic apply(input logic [2:0] v, input logic [31:0] pc, input logic [31:0] pred,
                         input logic br, input logic tk, input logic [31:0] tgt, input logic [31:0] fe);
        logic [31:0] succ;
        logic        me, mi;
        logic [2:0]  ke, ki;
        exp_t        e;
        @(negedge clk);
        stg_vld = v; rs_pc = pc; rs_pred_npc = pred; rs_is_br = br;
        rs_taken = tk; rs_target = tgt; fe_pred_npc = fe;
        #1;
        succ = (br && tk) ? tgt : pc + 32'd4;                   // R1
        me = !rst && v[2] && (succ != pred);
        mi = !rst && v[1] && (succ != pred);
        ke = me ? 3'b011 : 3'b000;                               // R4
        ki = mi ? 3'b001 : 3'b000;
        check(rv_e == me, "R2/R3/R5/R8 redirect (EX)", 64'(rv_e), 64'(me));
        check(rv_i == mi, "R2/R3/R5/R8 redirect (ID)", 64'(rv_i), 64'(mi));
        check(kill_e == ke, "R4 kill (EX)", 64'(kill_e), 64'(ke));
        check(kill_i == ki, "R4 kill (ID)", 64'(kill_i), 64'(ki));
        check(live_e == (v & ~ke), "R9 live (EX)", 64'(live_e), 64'(v & ~ke));
        check(live_i == (v & ~ki), "R9 live (ID)", 64'(live_i), 64'(v & ~ki));
        if (me) check(rp_e == succ, "R1 redirect pc (EX)", 64'(rp_e), 64'(succ));
        if (mi) check(rp_i == succ, "R1 redirect pc (ID)", 64'(rp_i), 64'(succ));
        check(fn_e == (me ? succ : fe), "R6 fetch pc (EX)", 64'(fn_e), 64'(me ? succ : fe));
        check(fn_i == (mi ? succ : fe), "R6 fetch pc (ID)", 64'(fn_i), 64'(mi ? succ : fe));
        e.ve = !rst && v[2] && br; e.vi = !rst && v[1] && br;
        e.me = me; e.mi = mi; e.tk = tk; e.pc = pc; e.tgt = tgt;
        q.push_back(e);
    endtask

    // Monitor: compares the training record one edge after each applied cycle.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(uv_e == e.ve, "R7 upd_vld (EX)", 64'(uv_e), 64'(e.ve));
                check(uv_i == e.vi, "R7 upd_vld (ID)", 64'(uv_i), 64'(e.vi));
                if (e.ve) begin
                    check(up_e == e.pc && utg_e == e.tgt && ut_e == e.tk, "R7 record (EX)",
                          {up_e, utg_e}, {e.pc, e.tgt});
                    check(um_e == e.me, "R7 mispred flag (EX)", 64'(um_e), 64'(e.me));
                end
                if (e.vi) begin
                    check(up_i == e.pc && utg_i == e.tgt && ut_i == e.tk, "R7 record (ID)",
                          {up_i, utg_i}, {e.pc, e.tgt});
                    check(um_i == e.mi, "R7 mispred flag (ID)", 64'(um_i), 64'(e.mi));
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R8: mispredicting stimulus held under reset
        apply(3'b111, 32'h100, 32'h104, 1'b1, 1'b1, 32'h200, 32'h500);
        apply(3'b111, 32'h100, 32'h104, 1'b1, 1'b1, 32'h200, 32'h500);
        @(negedge clk); rst = 1'b0;
        // R3: taken branch, correctly predicted
        apply(3'b111, 32'h1000, 32'h0800, 1'b1, 1'b1, 32'h0800, 32'h1100);
        // R2/R4: taken branch predicted sequential
        apply(3'b111, 32'h1000, 32'h1004, 1'b1, 1'b1, 32'h0800, 32'h1100);
        // R1/R2: not-taken branch predicted taken
        apply(3'b111, 32'h2000, 32'h2400, 1'b1, 1'b0, 32'h2400, 32'h3000);
        // R3: not-taken branch predicted sequential
        apply(3'b111, 32'h2000, 32'h2004, 1'b1, 1'b0, 32'h2400, 32'h3000);
        // R2/R7: non-branch with stale prediction flushes, no record
        apply(3'b111, 32'h3000, 32'h3800, 1'b0, 1'b1, 32'h3800, 32'h3010);
        // R5: execute empty, decode valid: only the decode-resolving copy reacts
        apply(3'b010, 32'h4000, 32'h4004, 1'b1, 1'b1, 32'h4400, 32'h4008);
        // R5: nothing valid at either resolve stage
        apply(3'b001, 32'h4000, 32'h4004, 1'b1, 1'b1, 32'h4400, 32'h4008);
        // R1: sequential successor wraps
        apply(3'b111, 32'hFFFF_FFFC, 32'h0000_1000, 1'b1, 1'b0, 32'h10, 32'h20);
        // R7: back-to-back branches
        apply(3'b111, 32'h5000, 32'h5004, 1'b1, 1'b0, 32'h5100, 32'h5008);
        apply(3'b110, 32'h5004, 32'h5200, 1'b1, 1'b1, 32'h5200, 32'h500C);
        apply(3'b101, 32'h5200, 32'h5204, 1'b1, 1'b1, 32'h6000, 32'h5208);
        apply(3'b000, 32'h0, 32'h4, 1'b0, 1'b0, 32'h0, 32'h0);
        @(negedge clk);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule